// File: doc/BRIEF.md
# Single-Port Storage Host Adapter Register File

This block holds the software-visible control registers of a single-port AHCI host adapter: the global host control words and the register window of port 0. Software reaches it through a simple word-addressed write port with byte strobes and a read port that returns data one cycle after the request. Hardware on the other side raises port interrupt events, clears indirectly-cleared status bits and acknowledges the adapter reset. The block drives the interrupt line, the reset request and the two base addresses (command list and received-frame area) that the transfer engines use.

Every register bit has one of four access behaviours: fixed (read-only), plain read/write, write-one-to-clear, or write-one-to-set with a hardware clear. A write is merged with the old value lane by lane under the byte strobes. The global pending word is fed from the port interrupt status, and the interrupt line combines it with the global enable.

Top module: `hba_regfile`

## Requirements
- R1: After reset every writable and clearable bit is 0: the global control word (word 1) reads 0x80000000, global pending (word 2) and port status (word 0x44) read 0, and irq_o, hba_reset_o, clb_o and fb_o are 0.
- R2: Word 0 (capabilities) reads 0x00240020, word 3 (ports implemented) reads 0x00000001 and word 4 (version) reads 0x00010301. Writes to these words change nothing.
- R3: In the global control word, bit 31 always reads 1 and ignores writes, and bit 1 (interrupt enable) is plain read/write.
- R4: Global control bit 0 (adapter reset) is set by writing 1, is not changed by writing 0, and is cleared only by a one-cycle pulse on hr_done_i. If a set and hr_done_i coincide, the set wins. hba_reset_o equals this bit.
- R5: Global pending bit 0 (word 2) is write-one-to-clear. It is set on the clock edge after any port status bit is 1, and while port status is non-zero, a software clear does not clear it.
- R6: irq_o is 1 exactly when interrupt enable (word 1 bit 1) and global pending bit 0 are both 1.
- R7: Command list base (word 0x40) is writable in bits 31:10 and the received-frame base (word 0x42) is writable in bits 31:8. The other bits read 0. clb_o and fb_o show the stored values, and the upper-address words 0x41 and 0x43 read 0.
- R8: Port status (word 0x44) bits 31:26, 24, 23, 5 and 3:0 are write-one-to-clear. A 1 on port_evt_i sets the matching implemented bit at the next edge, and a set beats a software clear of the same bit in the same cycle.
- R9: Port status bits 22, 7, 6 and 4 are set by port_evt_i, ignore software writes, and are cleared by a 1 on the matching bit of ind_clr_i. ind_clr_i has no effect on any other bit.
- R10: Byte strobe bit k gates bits 8k+7:8k of a write. A lane whose strobe is 0 keeps its old value.
- R11: Unimplemented words (5 to 10, every unlisted word, and the upper-address words) and all reserved bits read 0 and ignore writes.
- R12: rd_valid_o is 1 exactly one cycle after rd_en_i. rd_data_o then holds the word as it stood at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | ADDR_W | Word address of write |
| wr_data_i | input | 32 | Write data |
| wr_strb_i | input | 4 | Byte lane strobes |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Word address of read |
| rd_data_o | output | 32 | Read data, one cycle after request |
| rd_valid_o | output | 1 | Read data valid |
| port_evt_i | input | 32 | Per-bit port event pulses |
| ind_clr_i | input | 32 | Hardware clear for indirectly-cleared port status bits |
| hr_done_i | input | 1 | Adapter reset completed |
| irq_o | output | 1 | Interrupt line |
| hba_reset_o | output | 1 | Adapter reset request |
| clb_o | output | 32 | Command list base address |
| fb_o | output | 32 | Received-frame area base address |

## Verification
The bench targets the places where the access types meet. A write of 0 to the reset bit must not clear it, and a design that treats that bit as read/write would drop the reset request early. A simultaneous event and software clear must leave the status bit set, or an interrupt would be lost. The indirectly-cleared status bits must survive an all-ones software write, and a write with partial strobes must leave the unstrobed lanes alone; a design that merged the whole word would corrupt the base addresses or clear status that was never acknowledged. The bench also checks the one-cycle lag from port event to interrupt, and that a global pending clear does not take effect while port status is still non-zero.

// File: rtl/hba_regs_pkg.sv
package hba_regs_pkg;
  localparam int REG_W  = 32;
  localparam int STRB_W = REG_W / 8;

  // word indices (byte offset / 4)
  localparam int W_CAP  = 'h00;
  localparam int W_GHC  = 'h01;
  localparam int W_IS   = 'h02;
  localparam int W_PI   = 'h03;
  localparam int W_VS   = 'h04;
  localparam int W_CLB  = 'h40;
  localparam int W_FB   = 'h42;
  localparam int W_PXIS = 'h44;

  localparam logic [REG_W-1:0] CAP_VAL = 32'h0024_0020;
  localparam logic [REG_W-1:0] PI_VAL  = 32'h0000_0001;
  localparam logic [REG_W-1:0] VS_VAL  = 32'h0001_0301;

  localparam logic [REG_W-1:0] GHC_AE_M  = 32'h8000_0000;
  localparam logic [REG_W-1:0] GHC_RW_M  = 32'h0000_0002;
  localparam logic [REG_W-1:0] GHC_RW1_M = 32'h0000_0001;

  localparam logic [REG_W-1:0] CLB_RW_M = 32'hFFFF_FC00;
  localparam logic [REG_W-1:0] FB_RW_M  = 32'hFFFF_FF00;

  localparam logic [REG_W-1:0] PXIS_RWC_M  = 32'hFD80_002F;
  localparam logic [REG_W-1:0] PXIS_IND_M  = 32'h0040_00D0;
  localparam logic [REG_W-1:0] PXIS_IMPL_M = PXIS_RWC_M | PXIS_IND_M;

  function automatic logic [REG_W-1:0] lane_mask(input logic [STRB_W-1:0] s);
    logic [REG_W-1:0] m;
    for (int k = 0; k < STRB_W; k++) m[8*k +: 8] = {8{s[k]}};
    return m;
  endfunction

  // merge one write into a word according to per-bit access type
  function automatic logic [REG_W-1:0] apply_wr(
    input logic [REG_W-1:0] old_v,
    input logic [REG_W-1:0] wd,
    input logic [REG_W-1:0] hit,
    input logic [REG_W-1:0] rw_m,
    input logic [REG_W-1:0] rwc_m,
    input logic [REG_W-1:0] rw1_m
  );
    logic [REG_W-1:0] r;
    r = (old_v & ~(hit & rw_m)) | (wd & hit & rw_m);
    r = r & ~(wd & hit & rwc_m);
    r = r | (wd & hit & rw1_m);
    return r;
  endfunction
endpackage

// File: rtl/hba_ghc.sv
module hba_ghc
  import hba_regs_pkg::*;
#(
  parameter int NUM_PORTS = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] ctl_hit_i,
  input  logic [REG_W-1:0] is_hit_i,
  input  logic [REG_W-1:0] wd_i,
  input  logic             hr_done_i,
  input  logic [NUM_PORTS-1:0] port_pend_i,
  output logic [REG_W-1:0] ctl_o,
  output logic [REG_W-1:0] is_o,
  output logic             irq_o,
  output logic             hba_reset_o
);
  localparam logic [REG_W-1:0] IS_M =
    (NUM_PORTS >= REG_W) ? '1 : ((REG_W'(1) << NUM_PORTS) - REG_W'(1));

  logic [REG_W-1:0] ctl_q, ctl_n, is_q, is_n, pend_w;
  logic hr_set;

  always_comb begin
    pend_w = '0;
    pend_w[NUM_PORTS-1:0] = port_pend_i;
  end

  always_comb begin
    hr_set = ctl_hit_i[0] & wd_i[0];
    ctl_n  = apply_wr(ctl_q, wd_i, ctl_hit_i, GHC_RW_M, '0, GHC_RW1_M);
    // hardware clear of reset bit loses to a same-cycle software set
    ctl_n[0] = ctl_n[0] & ~(hr_done_i & ~hr_set);
    ctl_n  = ctl_n & (GHC_RW_M | GHC_RW1_M);
    is_n   = (apply_wr(is_q, wd_i, is_hit_i, '0, IS_M, '0) | pend_w) & IS_M;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      is_q  <= '0;
    end else begin
      ctl_q <= ctl_n;
      is_q  <= is_n;
    end
  end

  assign ctl_o       = ctl_q | GHC_AE_M;
  assign is_o        = is_q;
  assign irq_o       = ctl_q[1] & (|is_q);
  assign hba_reset_o = ctl_q[0];
endmodule

// File: rtl/hba_port.sv
module hba_port
  import hba_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] clb_hit_i,
  input  logic [REG_W-1:0] fb_hit_i,
  input  logic [REG_W-1:0] is_hit_i,
  input  logic [REG_W-1:0] wd_i,
  input  logic [REG_W-1:0] evt_i,
  input  logic [REG_W-1:0] ind_clr_i,
  output logic [REG_W-1:0] clb_o,
  output logic [REG_W-1:0] fb_o,
  output logic [REG_W-1:0] pxis_o
);
  logic [REG_W-1:0] clb_q, fb_q, pxis_q, pxis_n;

  always_comb begin
    pxis_n = apply_wr(pxis_q, wd_i, is_hit_i, '0, PXIS_RWC_M, '0);
    pxis_n = pxis_n & ~(ind_clr_i & PXIS_IND_M);
    pxis_n = pxis_n | (evt_i & PXIS_IMPL_M); // event set wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clb_q  <= '0;
      fb_q   <= '0;
      pxis_q <= '0;
    end else begin
      clb_q  <= apply_wr(clb_q, wd_i, clb_hit_i, CLB_RW_M, '0, '0);
      fb_q   <= apply_wr(fb_q, wd_i, fb_hit_i, FB_RW_M, '0, '0);
      pxis_q <= pxis_n;
    end
  end

  assign clb_o  = clb_q;
  assign fb_o   = fb_q;
  assign pxis_o = pxis_q;
endmodule

// File: rtl/hba_rd_mux.sv
module hba_rd_mux
  import hba_regs_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [REG_W-1:0]  ctl_i,
  input  logic [REG_W-1:0]  is_i,
  input  logic [REG_W-1:0]  clb_i,
  input  logic [REG_W-1:0]  fb_i,
  input  logic [REG_W-1:0]  pxis_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              rd_valid_o
);
  logic [REG_W-1:0] sel;

  always_comb begin
    case (rd_addr_i)
      ADDR_W'(W_CAP):  sel = CAP_VAL;
      ADDR_W'(W_GHC):  sel = ctl_i;
      ADDR_W'(W_IS):   sel = is_i;
      ADDR_W'(W_PI):   sel = PI_VAL;
      ADDR_W'(W_VS):   sel = VS_VAL;
      ADDR_W'(W_CLB):  sel = clb_i;
      ADDR_W'(W_FB):   sel = fb_i;
      ADDR_W'(W_PXIS): sel = pxis_i;
      default:         sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= sel;
    end
  end
endmodule

// File: rtl/hba_regfile.sv
module hba_regfile
  import hba_regs_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [3:0]        wr_strb_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              rd_valid_o,
  input  logic [31:0]       port_evt_i,
  input  logic [31:0]       ind_clr_i,
  input  logic              hr_done_i,
  output logic              irq_o,
  output logic              hba_reset_o,
  output logic [31:0]       clb_o,
  output logic [31:0]       fb_o
);
  localparam int NUM_PORTS = 1;

  logic [REG_W-1:0] lanes, ctl_w, is_w, pxis_w;
  logic [REG_W-1:0] ctl_hit, is_hit, clb_hit, fb_hit, pxis_hit;

  function automatic logic [REG_W-1:0] hit_for(input int idx);
    return (wr_en_i && wr_addr_i == ADDR_W'(idx)) ? lanes : '0;
  endfunction

  always_comb begin
    lanes    = lane_mask(wr_strb_i);
    ctl_hit  = hit_for(W_GHC);
    is_hit   = hit_for(W_IS);
    clb_hit  = hit_for(W_CLB);
    fb_hit   = hit_for(W_FB);
    pxis_hit = hit_for(W_PXIS);
  end

  hba_ghc #(.NUM_PORTS(NUM_PORTS)) u_ghc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_hit_i   (ctl_hit),
    .is_hit_i    (is_hit),
    .wd_i        (wr_data_i),
    .hr_done_i   (hr_done_i),
    .port_pend_i (|pxis_w),
    .ctl_o       (ctl_w),
    .is_o        (is_w),
    .irq_o       (irq_o),
    .hba_reset_o (hba_reset_o)
  );

  hba_port u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clb_hit_i (clb_hit),
    .fb_hit_i  (fb_hit),
    .is_hit_i  (pxis_hit),
    .wd_i      (wr_data_i),
    .evt_i     (port_evt_i),
    .ind_clr_i (ind_clr_i),
    .clb_o     (clb_o),
    .fb_o      (fb_o),
    .pxis_o    (pxis_w)
  );

  hba_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .ctl_i      (ctl_w),
    .is_i       (is_w),
    .clb_i      (clb_o),
    .fb_i       (fb_o),
    .pxis_i     (pxis_w),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );
endmodule

// File: rtl/hba_regfile_chk.sv
module hba_regfile_chk
  import hba_regs_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              wd0_i,
  input logic              strb0_i,
  input logic              rd_en_i,
  input logic              rd_valid_o,
  input logic [31:0]       port_evt_i,
  input logic              hr_done_i,
  input logic              hba_reset_o,
  input logic [31:0]       pxis_i,
  input logic              is0_i
);
  logic hr_wset;
  assign hr_wset = wr_en_i && wr_addr_i == ADDR_W'(W_GHC) && strb0_i && wd0_i;

  a_r4_hr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hr_wset |=> hba_reset_o);
  a_r4_hr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hba_reset_o && !hr_done_i) |=> hba_reset_o);
  a_r4_hr_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hba_reset_o && hr_done_i && !hr_wset) |=> !hba_reset_o);
  a_r8_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|port_evt_i) |=> ((pxis_i & $past(port_evt_i & PXIS_IMPL_M)) == $past(port_evt_i & PXIS_IMPL_M)));
  a_r5_is_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pxis_i != '0) |=> is0_i);
  a_r12_rd_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  a_r12_rd_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
endmodule

bind hba_regfile hba_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wd0_i       (wr_data_i[0]),
  .strb0_i     (wr_strb_i[0]),
  .rd_en_i     (rd_en_i),
  .rd_valid_o  (rd_valid_o),
  .port_evt_i  (port_evt_i),
  .hr_done_i   (hr_done_i),
  .hba_reset_o (hba_reset_o),
  .pxis_i      (pxis_w),
  .is0_i       (is_w[0])
);

// File: tb/sim_hba_regfile.sv
`timescale 1ns/1ps
module sim_hba_regfile;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, hr_done = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, evt = '0, ind_clr = '0;
  logic [3:0] wr_strb = '0;
  logic [31:0] rd_data, clb, fb;
  logic rd_valid, irq, hba_reset;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  hba_regfile #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .port_evt_i(evt), .ind_clr_i(ind_clr), .hr_done_i(hr_done),
    .irq_o(irq), .hba_reset_o(hba_reset), .clb_o(clb), .fb_o(fb)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // all driver tasks start and end on a falling edge
  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] s);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_strb = s;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = '0;
  endtask

  task automatic wr_evt(input int a, input logic [31:0] d, input logic [31:0] e);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_strb = 4'hF; evt = e;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = '0; evt = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    rd_en = 1'b1; rd_addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_evt(input logic [31:0] e);
    evt = e; @(negedge clk); evt = '0;
  endtask

  task automatic pulse_clr(input logic [31:0] c);
    ind_clr = c; @(negedge clk); ind_clr = '0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 unexpected read data actual=0x%08h expected=none", rd_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_o", {31'b0, irq}, 0);
    check("R1 hba_reset_o", {31'b0, hba_reset}, 0);
    check("R1 clb_o", clb, 0);
    check("R1 fb_o", fb, 0);
    check("R12 idle rd_valid_o", {31'b0, rd_valid}, 0);
    rd(1, 32'h8000_0000, "R1 ghc reset");
    rd(2, 0, "R1 global pending reset");
    rd(32'h44, 0, "R1 port status reset");
    // R2 constants
    rd(0, 32'h0024_0020, "R2 capabilities");
    rd(3, 1, "R2 ports implemented");
    rd(4, 32'h0001_0301, "R2 version");
    wr(0, 32'hFFFF_FFFF, 4'hF);
    wr(4, 0, 4'hF);
    rd(0, 32'h0024_0020, "R2 capabilities after write");
    rd(4, 32'h0001_0301, "R2 version after write");
    // R11 unimplemented words
    wr(5, 32'hFFFF_FFFF, 4'hF);
    wr(9, 32'hFFFF_FFFF, 4'hF);
    wr(10, 32'hFFFF_FFFF, 4'hF);
    wr(32'h30, 32'hFFFF_FFFF, 4'hF);
    wr(32'h41, 32'hFFFF_FFFF, 4'hF);
    wr(32'h43, 32'hFFFF_FFFF, 4'hF);
    rd(5, 0, "R11 word 5");
    rd(9, 0, "R11 word 9");
    rd(10, 0, "R11 word 10");
    rd(32'h30, 0, "R11 unlisted word");
    rd(32'h41, 0, "R11 R7 clb upper");
    rd(32'h43, 0, "R11 R7 fb upper");
    // R3 global control
    wr(1, 32'h0000_0002, 4'hF);
    rd(1, 32'h8000_0002, "R3 enable set");
    wr(1, 0, 4'hF);
    rd(1, 32'h8000_0000, "R3 bit31 stays, enable cleared");
    // R4 adapter reset
    wr(1, 32'h0000_0003, 4'hF);
    check("R4 hba_reset_o after set", {31'b0, hba_reset}, 1);
    rd(1, 32'h8000_0003, "R4 reset bit set");
    wr(1, 32'h0000_0002, 4'hF);
    rd(1, 32'h8000_0003, "R4 write 0 no effect");
    hr_done = 1'b1; @(negedge clk); hr_done = 1'b0;
    check("R4 hba_reset_o after done", {31'b0, hba_reset}, 0);
    rd(1, 32'h8000_0002, "R4 hardware clear");
    // R10 strobe on ghc: lane 0 unstrobed keeps enable
    wr(1, 0, 4'b1110);
    rd(1, 32'h8000_0002, "R10 ghc lane 0 kept");
    // R7 base addresses
    wr(32'h40, 32'hFFFF_FFFF, 4'hF);
    rd(32'h40, 32'hFFFF_FC00, "R7 clb alignment");
    check("R7 clb_o", clb, 32'hFFFF_FC00);
    wr(32'h42, 32'h1234_5678, 4'hF);
    rd(32'h42, 32'h1234_5600, "R7 fb alignment");
    wr(32'h40, 0, 4'b0100);
    rd(32'h40, 32'hFF00_FC00, "R10 clb single lane");
    wr(32'h42, 32'hAABB_CCDD, 4'b1001);
    rd(32'h42, 32'hAA34_5600, "R10 fb two lanes");
    check("R7 fb_o", fb, 32'hAA34_5600);
    // R5/R6/R8 events (enable is 1)
    pulse_evt(32'h0000_0001);
    check("R5 pending lags one cycle", {31'b0, irq}, 0);
    @(negedge clk);
    check("R6 irq_o asserted", {31'b0, irq}, 1);
    rd(32'h44, 1, "R8 event sets bit 0");
    rd(2, 1, "R5 global pending set");
    wr(2, 1, 4'hF);
    rd(2, 1, "R5 clear blocked while port status set");
    pulse_evt(32'hFFFF_FFFF);
    rd(32'h44, 32'hFDC0_00FF, "R8 implemented bits only");
    wr(32'h44, 32'hFFFF_FFFF, 4'hF);
    rd(32'h44, 32'h0040_00D0, "R9 indirect bits ignore writes");
    pulse_clr(32'hFFFF_FFFF);
    rd(32'h44, 0, "R9 indirect clear");
    pulse_evt(32'h0100_0001);
    pulse_clr(32'hFFFF_FFFF);
    rd(32'h44, 32'h0100_0001, "R9 indirect clear spares other bits");
    wr(32'h44, 32'hFFFF_FFFF, 4'b0001);
    rd(32'h44, 32'h0100_0000, "R10 status lane 3 unstrobed");
    wr_evt(32'h44, 32'h0100_0000, 32'h0100_0000);
    rd(32'h44, 32'h0100_0000, "R8 set beats clear");
    wr(32'h44, 32'hFFFF_FFFF, 4'hF);
    rd(32'h44, 0, "R8 clear");
    // R6 enable gating
    wr(1, 0, 4'hF);
    check("R6 irq_o disabled", {31'b0, irq}, 0);
    rd(2, 1, "R5 pending held");
    wr(2, 1, 4'hF);
    rd(2, 0, "R5 pending cleared");
    wr(1, 32'h0000_0002, 4'hF);
    check("R6 irq_o no pending", {31'b0, irq}, 0);
    @(negedge clk);
    @(negedge clk);
    check("R12 all reads returned", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule